// File: doc/BRIEF.md
# Power-of-Two Window Frequency Comparator

This block compares an oscillator clock with a reference clock and reports whether the oscillator runs at the requested multiple `targetN` of the reference. An edge counter in the oscillator domain runs without stopping. Its value crosses into the reference domain as Gray code through a two-flop synchronizer. A reference-domain timer opens a measurement window and closes it after exactly 2^i reference periods, where i is the `sampleIdx` input. The oscillator count taken over that window is split at bit i. The upper slice is the quotient, which should equal N. The lower i bits are the remainder, the fractional part of the error.

A quotient that matches N gives a zero result, and counting continues. An upstream loop controller can then raise the index and get a finer measurement from the same window start. A mismatch gives +1 or -1. A mismatch, a clear request, or reaching the largest window clears both counters. The oscillator-side clear is a toggle handshake, and it must be acknowledged before the next window opens. The caller sees a two-bit signed result, a one-cycle valid strobe, and a flag that marks a match whose remainder is below a programmable threshold.

Top module: `freq_window_cmp`

## Requirements
- R1: While `rstN` is low, `resultValid` and `withinThresh` are 0 and `result` is 2'b00.
- R2: When the quotient (window count shifted right by i, L bits wide, with L = ceil(log2(MAX_N+1))) is below `targetN`, the block reports `result` = 2'b01 (+1, the oscillator is slow).
- R3: When the quotient is above `targetN`, the block reports `result` = 2'b11 (-1, the oscillator is fast).
- R4: When the quotient equals `targetN`, the block reports `result` = 2'b00 and the window keeps counting. If the index is then raised from i to i+1, the next result comes 2^i reference cycles after the previous one and is measured from the same window start.
- R5: A nonzero result clears both counters and runs the clear handshake. The next result therefore comes at least 9 reference cycles later, even for a window of 4 cycles.
- R6: `withinThresh` is 1 only together with a zero result whose remainder (the low i bits of the count) is strictly less than `remThresh`.
- R7: When `targetN` is 0 or greater than MAX_N, no comparison is made and `resultValid` stays 0. `targetN` equal to MAX_N is accepted.
- R8: `resultValid` is high for exactly one cycle. Each comparison takes place exactly 2^i reference cycles after its window opened.
- R9: `clearReq` aborts the current window. No result is reported in the cycle after it, and the next result comes no sooner than 2^i cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock |
| oscClk | input | 1 | Oscillator clock being measured |
| rstN | input | 1 | Asynchronous active-low reset, both domains |
| targetN | input | CW | Requested multiplication factor |
| sampleIdx | input | IW | Window index i, window = 2^i reference cycles |
| remThresh | input | MAX_IDX | Remainder threshold for the match flag |
| clearReq | input | 1 | Abort the window and clear both counters |
| result | output | 2 | Signed comparison: 01 = +1, 11 = -1, 00 = match |
| resultValid | output | 1 | One-cycle strobe marking a new result |
| withinThresh | output | 1 | Match with a remainder below the threshold |

## Verification
The hardest situation to reach from the ports is a window that keeps running past a match while the index steps up. Only then does the zero-result path show that the base count was kept. The bench holds the oscillator at a ratio that gives a clear match at index 2. It raises the index at the negative edge where the first strobe is seen and checks that the second strobe comes four cycles later with a consistent quotient. The abort path is harder to see, because nothing is reported for it. The bench issues two clear requests ten cycles apart and checks that the one result which follows arrives no sooner than a full window after the second request.

// File: rtl/fcmp_pkg.sv
`timescale 1ns/1ps
package fcmp_pkg;

  typedef struct packed {
    logic loadBase;   // capture window start count
    logic doCompare;  // window closes this cycle
  } fcmp_strobe_t;

  typedef enum logic [1:0] {
    ST_REQ,
    ST_WAIT,
    ST_SETTLE,
    ST_RUN
  } fcmp_state_t;

  localparam logic [1:0] RES_ZERO = 2'b00;
  localparam logic [1:0] RES_UP   = 2'b01;
  localparam logic [1:0] RES_DOWN = 2'b11;

endpackage

// File: rtl/fcmp_osc_side.sv
`timescale 1ns/1ps
module fcmp_osc_side #(
  parameter int TOTW = 14
) (
  input  logic            oscClk,
  input  logic            rstN,
  input  logic            clrReqTgl,
  output logic [TOTW-1:0] oscGray,
  output logic            clrAckTgl
);

  logic [TOTW-1:0] edgeCnt;
  logic [TOTW-1:0] cntNext;
  logic            reqSync1;
  logic            reqSync2;

  assign cntNext = edgeCnt + TOTW'(1);

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      reqSync1  <= 1'b0;
      reqSync2  <= 1'b0;
      clrAckTgl <= 1'b0;
      edgeCnt   <= '0;
      oscGray   <= '0;
    end else begin
      reqSync1 <= clrReqTgl;
      reqSync2 <= reqSync1;
      if (reqSync2 != clrAckTgl) begin
        edgeCnt   <= '0;
        oscGray   <= '0;
        clrAckTgl <= reqSync2;
      end else begin
        edgeCnt <= cntNext;
        oscGray <= cntNext ^ (cntNext >> 1);
      end
    end
  end

endmodule

// File: rtl/fcmp_ctrl.sv
`timescale 1ns/1ps
module fcmp_ctrl
  import fcmp_pkg::*;
#(
  parameter int MAX_N   = 200,
  parameter int MAX_IDX = 6,
  parameter int CW      = 8,
  parameter int IW      = 3
) (
  input  logic          refClk,
  input  logic          rstN,
  input  logic [CW-1:0] targetN,
  input  logic [IW-1:0] sampleIdx,
  input  logic          clearReq,
  input  logic          clrAckTgl,
  input  logic          mismatch,
  output logic          clrReqTgl,
  output fcmp_strobe_t  strb
);

  localparam int RCW = MAX_IDX + 1;

  fcmp_state_t    state;
  logic [RCW-1:0] refCnt;
  logic           ackSync1;
  logic           ackSync2;
  logic           settleCnt;
  logic           nOk;
  logic           idxOk;
  logic           winHit;
  logic           lastWin;
  logic           restart;

  assign nOk     = (targetN != '0) && (targetN <= CW'(MAX_N));
  assign idxOk   = sampleIdx <= IW'(MAX_IDX);
  assign winHit  = (state == ST_RUN) && idxOk && (refCnt == (RCW'(1) << sampleIdx));
  assign lastWin = (state == ST_RUN) && (refCnt == (RCW'(1) << MAX_IDX));

  assign strb.doCompare = winHit && nOk && !clearReq;
  assign strb.loadBase  = (state == ST_RUN) && (refCnt == '0);
  assign restart        = clearReq || (strb.doCompare && mismatch) || lastWin;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      ackSync1 <= 1'b0;
      ackSync2 <= 1'b0;
    end else begin
      ackSync1 <= clrAckTgl;
      ackSync2 <= ackSync1;
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_REQ;
      clrReqTgl <= 1'b0;
      refCnt    <= '0;
      settleCnt <= 1'b0;
    end else begin
      case (state)
        ST_REQ: begin
          clrReqTgl <= ~clrReqTgl;
          state     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ackSync2 == clrReqTgl) begin
            settleCnt <= 1'b0;
            state     <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          settleCnt <= 1'b1;
          if (settleCnt) begin
            refCnt <= '0;
            state  <= ST_RUN;
          end
        end
        default: begin
          if (restart) state <= ST_REQ;
          else         refCnt <= refCnt + RCW'(1);
        end
      endcase
    end
  end

endmodule

// File: rtl/fcmp_datapath.sv
`timescale 1ns/1ps
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int MAX_IDX = 6,
  parameter int CW      = 8,
  parameter int IW      = 3,
  parameter int TOTW    = 14
) (
  input  logic               refClk,
  input  logic               rstN,
  input  logic [TOTW-1:0]    oscGray,
  input  fcmp_strobe_t       strb,
  input  logic [CW-1:0]      targetN,
  input  logic [IW-1:0]      sampleIdx,
  input  logic [MAX_IDX-1:0] remThresh,
  output logic               mismatch,
  output logic [1:0]         result,
  output logic               resultValid,
  output logic               withinThresh
);

  logic [TOTW-1:0]    graySync1;
  logic [TOTW-1:0]    graySync2;
  logic [TOTW-1:0]    binNow;
  logic [TOTW-1:0]    baseCnt;
  logic [TOTW-1:0]    delta;
  logic [TOTW-1:0]    shifted;
  logic [TOTW-1:0]    remMask;
  logic [CW-1:0]      quot;
  logic [MAX_IDX-1:0] remBits;
  logic               over;
  logic               quotEq;
  logic               quotLow;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      graySync1 <= '0;
      graySync2 <= '0;
    end else begin
      graySync1 <= oscGray;
      graySync2 <= graySync1;
    end
  end

  always_comb begin
    binNow[TOTW-1] = graySync2[TOTW-1];
    for (int k = TOTW - 2; k >= 0; k--) begin
      binNow[k] = binNow[k+1] ^ graySync2[k];
    end
  end

  assign delta   = binNow - baseCnt;
  assign shifted = delta >> sampleIdx;
  assign quot    = shifted[CW-1:0];
  assign over    = |shifted[TOTW-1:CW];
  assign remMask = (TOTW'(1) << sampleIdx) - TOTW'(1);
  assign remBits = MAX_IDX'(delta & remMask);
  assign quotEq  = !over && (quot == targetN);
  assign quotLow = !over && (quot < targetN);
  assign mismatch = !quotEq;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      baseCnt      <= '0;
      result       <= RES_ZERO;
      resultValid  <= 1'b0;
      withinThresh <= 1'b0;
    end else begin
      if (strb.loadBase) baseCnt <= binNow;
      resultValid  <= strb.doCompare;
      withinThresh <= strb.doCompare && quotEq && (remBits < remThresh);
      if (strb.doCompare) begin
        if (quotEq)       result <= RES_ZERO;
        else if (quotLow) result <= RES_UP;
        else              result <= RES_DOWN;
      end
    end
  end

endmodule

// File: rtl/freq_window_cmp.sv
`timescale 1ns/1ps
module freq_window_cmp
  import fcmp_pkg::*;
#(
  parameter int MAX_N   = 200,
  parameter int MAX_IDX = 6,
  localparam int CW     = $clog2(MAX_N + 1),
  localparam int IW     = $clog2(MAX_IDX + 1),
  localparam int TOTW   = CW + MAX_IDX
) (
  input  logic               refClk,
  input  logic               oscClk,
  input  logic               rstN,
  input  logic [CW-1:0]      targetN,
  input  logic [IW-1:0]      sampleIdx,
  input  logic [MAX_IDX-1:0] remThresh,
  input  logic               clearReq,
  output logic [1:0]         result,
  output logic               resultValid,
  output logic               withinThresh
);

  fcmp_strobe_t    strb;
  logic            clrReqTgl;
  logic            clrAckTgl;
  logic            mismatch;
  logic [TOTW-1:0] oscGray;

  fcmp_osc_side #(.TOTW(TOTW)) osc_i (
    .oscClk    (oscClk),
    .rstN      (rstN),
    .clrReqTgl (clrReqTgl),
    .oscGray   (oscGray),
    .clrAckTgl (clrAckTgl)
  );

  fcmp_ctrl #(.MAX_N(MAX_N), .MAX_IDX(MAX_IDX), .CW(CW), .IW(IW)) ctrl_i (
    .refClk    (refClk),
    .rstN      (rstN),
    .targetN   (targetN),
    .sampleIdx (sampleIdx),
    .clearReq  (clearReq),
    .clrAckTgl (clrAckTgl),
    .mismatch  (mismatch),
    .clrReqTgl (clrReqTgl),
    .strb      (strb)
  );

  fcmp_datapath #(.MAX_IDX(MAX_IDX), .CW(CW), .IW(IW), .TOTW(TOTW)) dp_i (
    .refClk       (refClk),
    .rstN         (rstN),
    .oscGray      (oscGray),
    .strb         (strb),
    .targetN      (targetN),
    .sampleIdx    (sampleIdx),
    .remThresh    (remThresh),
    .mismatch     (mismatch),
    .result       (result),
    .resultValid  (resultValid),
    .withinThresh (withinThresh)
  );

endmodule

// File: rtl/fcmp_checker.sv
`timescale 1ns/1ps
module fcmp_checker
  import fcmp_pkg::*;
#(
  parameter int MAX_N   = 200,
  parameter int MAX_IDX = 6,
  parameter int CW      = 8,
  parameter int IW      = 3
) (
  input logic          refClk,
  input logic          rstN,
  input logic [CW-1:0] targetN,
  input logic [IW-1:0] sampleIdx,
  input logic          clearReq,
  input logic [1:0]    result,
  input logic          resultValid,
  input logic          withinThresh,
  input fcmp_strobe_t  strb
);

  localparam int WCW = MAX_IDX + 2;

  logic [WCW-1:0] winCnt;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)              winCnt <= '0;
    else if (strb.loadBase) winCnt <= WCW'(1);
    else                    winCnt <= winCnt + WCW'(1);
  end

  assert_reset_quiet_R1: assert property (@(posedge refClk)
    !rstN |-> (!resultValid && !withinThresh && result == RES_ZERO));

  assert_result_code_R2: assert property (@(posedge refClk) disable iff (!rstN)
    resultValid |-> (result != 2'b10));

  assert_flag_match_R6: assert property (@(posedge refClk) disable iff (!rstN)
    withinThresh |-> (resultValid && result == RES_ZERO));

  assert_bad_n_R7: assert property (@(posedge refClk) disable iff (!rstN)
    resultValid |-> ($past(targetN) != '0 && $past(targetN) <= CW'(MAX_N)));

  assert_pulse_R8: assert property (@(posedge refClk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_window_len_R8: assert property (@(posedge refClk) disable iff (!rstN)
    strb.doCompare |-> (winCnt == (WCW'(1) << sampleIdx)));

  assert_clear_abort_R9: assert property (@(posedge refClk) disable iff (!rstN)
    clearReq |=> !resultValid);

endmodule

bind freq_window_cmp fcmp_checker #(
  .MAX_N(MAX_N), .MAX_IDX(MAX_IDX), .CW(CW), .IW(IW)
) chk_i (
  .refClk       (refClk),
  .rstN         (rstN),
  .targetN      (targetN),
  .sampleIdx    (sampleIdx),
  .clearReq     (clearReq),
  .result       (result),
  .resultValid  (resultValid),
  .withinThresh (withinThresh),
  .strb         (strb)
);

// File: tb/freq_window_cmp_tb.sv
`timescale 1ns/1ps
module freq_window_cmp_tb_top;

  localparam int MAX_N   = 200;
  localparam int MAX_IDX = 6;

  logic       refClk = 1'b0;
  logic       oscClk = 1'b0;
  logic       rstN   = 1'b0;
  logic [7:0] targetN = 8'd10;
  logic [2:0] sampleIdx = 3'd4;
  logic [5:0] remThresh = 6'd0;
  logic       clearReq = 1'b0;
  logic [1:0] result;
  logic       resultValid;
  logic       withinThresh;
  real        oscHalfNs = 0.952;

  int checks = 0;
  int errors = 0;

  freq_window_cmp #(.MAX_N(MAX_N), .MAX_IDX(MAX_IDX)) dut_i (
    .refClk       (refClk),
    .oscClk       (oscClk),
    .rstN         (rstN),
    .targetN      (targetN),
    .sampleIdx    (sampleIdx),
    .remThresh    (remThresh),
    .clearReq     (clearReq),
    .result       (result),
    .resultValid  (resultValid),
    .withinThresh (withinThresh)
  );

  always #10 refClk = ~refClk;
  always #(oscHalfNs) oscClk = ~oscClk;

  typedef struct packed {
    logic [15:0] halfPs;
    logic [7:0]  n;
    logic [2:0]  idx;
    logic [5:0]  thr;
    logic        expValid;
    logic [1:0]  expRes;
    logic        expWithin;
  } vec_t;

  // count over window = 2^idx * 20 ns / (2 * half period)
  localparam vec_t VECS [10] = '{
    '{16'd952,  8'd10,  3'd4, 6'd12, 1'b1, 2'b00, 1'b1},  // 168: q10 r8
    '{16'd952,  8'd10,  3'd4, 6'd4,  1'b1, 2'b00, 1'b0},  // 168: r8 >= 4
    '{16'd1250, 8'd10,  3'd4, 6'd12, 1'b1, 2'b01, 1'b0},  // 128: q8
    '{16'd750,  8'd10,  3'd4, 6'd12, 1'b1, 2'b11, 1'b0},  // 213: q13
    '{16'd952,  8'd10,  3'd2, 6'd0,  1'b1, 2'b00, 1'b0},  // 42: q10
    '{16'd952,  8'd10,  3'd6, 6'd40, 1'b1, 2'b00, 1'b1},  // 672: q10 r32
    '{16'd952,  8'd20,  3'd0, 6'd0,  1'b1, 2'b01, 1'b0},  // 10..11 < 20
    '{16'd5000, 8'd200, 3'd6, 6'd0,  1'b1, 2'b01, 1'b0},  // 128: q2, N = max
    '{16'd952,  8'd201, 3'd4, 6'd0,  1'b0, 2'b00, 1'b0},  // N above max
    '{16'd952,  8'd0,   3'd4, 6'd0,  1'b0, 2'b00, 1'b0}   // N zero
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitValid(input int maxCyc, output bit got, output int cyc);
    got = 1'b0;
    cyc = 0;
    while (cyc < maxCyc && !got) begin
      @(negedge refClk);
      cyc++;
      if (resultValid) got = 1'b1;
    end
  endtask

  task automatic setupAndClear(input vec_t v);
    @(negedge refClk);
    oscHalfNs = real'(v.halfPs) / 1000.0;
    targetN   = v.n;
    sampleIdx = v.idx;
    remThresh = v.thr;
    clearReq  = 1'b1;
    @(negedge refClk);
    clearReq  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge refClk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    int cyc;
    int gap;

    // R1: outputs quiet during reset
    repeat (4) @(negedge refClk);
    check(resultValid == 1'b0, "R1 valid", int'(resultValid), 0);
    check(withinThresh == 1'b0, "R1 within", int'(withinThresh), 0);
    check(result == 2'b00, "R1 result", int'(result), 0);
    rstN = 1'b1;

    // table of vectors
    for (int k = 0; k < 10; k++) begin
      setupAndClear(VECS[k]);
      waitValid(250, got, cyc);
      if (VECS[k].expValid) begin
        if (VECS[k].expRes == 2'b01)
          check(got && result == 2'b01, "R2", int'(result), 1);
        else if (VECS[k].expRes == 2'b11)
          check(got && result == 2'b11, "R3", int'(result), 3);
        else
          check(got && result == 2'b00, "R4", int'(result), 0);
        check(got && withinThresh == VECS[k].expWithin, "R6",
              int'(withinThresh), int'(VECS[k].expWithin));
        @(negedge refClk);
        check(resultValid == 1'b0, "R8 pulse", int'(resultValid), 0);
      end else begin
        check(!got, "R7 rejected N", int'(got), 0);
      end
    end

    // R4: match keeps counting; raising the index gives a result 2^i later
    setupAndClear('{16'd952, 8'd10, 3'd2, 6'd0, 1'b1, 2'b00, 1'b0});
    waitValid(250, got, cyc);
    check(got && result == 2'b00, "R4 first", int'(result), 0);
    sampleIdx = 3'd3;
    waitValid(50, got, gap);
    check(got && gap == 4, "R4 spacing", gap, 4);
    check(got && result == 2'b00, "R4 continued", int'(result), 0);

    // R5: mismatch restarts with handshake before next window
    setupAndClear('{16'd750, 8'd10, 3'd2, 6'd0, 1'b1, 2'b11, 1'b0});
    waitValid(250, got, cyc);
    check(got && result == 2'b11, "R3 small window", int'(result), 3);
    waitValid(100, got, gap);
    check(got && gap >= 9, "R5 restart gap", gap, 9);
    check(got && result == 2'b11, "R5 repeat", int'(result), 3);

    // R9: clear aborts; next result a full window after the last clear
    setupAndClear('{16'd952, 8'd10, 3'd5, 6'd0, 1'b1, 2'b00, 1'b0});
    waitValid(9, got, cyc);
    check(!got, "R9 no early result", int'(got), 0);
    clearReq = 1'b1;
    @(negedge refClk);
    clearReq = 1'b0;
    waitValid(120, got, gap);
    check(got && gap >= 32 && gap <= 60, "R9 window after clear", gap, 40);
    check(got && result == 2'b00, "R9 result", int'(result), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule